// File: doc/BRIEF.md
# User Return Segment and Target Finalizer

This block performs the last stage of a return from a kernel event handler to user mode. It receives a return frame whose basic shape has already been checked: instruction pointer, code and stack selectors, flags image, stack pointer, and two event flags. It then works out the user-mode state to install. When the selector pair matches one of two fixed offsets from a configurable selector base, the block builds the code and stack descriptors itself, with no table access. Those two fast paths are 64-bit and compatibility. Any other pair goes to an external descriptor-table walker through a request/acknowledge handshake.

With the code descriptor settled, the block applies the mode-dependent rules. In 64-bit mode the instruction pointer must be canonical. In compatibility mode the upper halves of the instruction and stack pointers are cleared and the pointer is checked against the scaled segment limit. The block also checks both shadow stacks. On success it raises the privilege level to 3, swaps the GS base with the kernel GS base, and optionally loads the shadow-stack pointer. It can also request NMI unblocking or a pending single-step trap. On failure it reports a fault kind and error code and leaves every state output untouched.

Top module: `user_return_finalizer`

## Requirements
- R1: The 64-bit fast path is taken when the CS selector equals base+16 and the SS selector equals base+8. It loads a CS descriptor with base 0, limit 0xFFFFF, type 11, S=1, DPL=3, P=1, L=1, D=0, G=1, and an SS descriptor with the same fields except type 3, L=0, B=1. The descriptor vector packs these fields from the MSB down as base[31:0], limit[19:0], type[3:0], S, DPL[1:0], P, L, D/B, G, so G is bit 0, D/B bit 1 and L bit 2.
- R2: The compatibility fast path is taken when the CS selector equals base and the SS selector equals base+8. It uses the R1 descriptors except that CS has L=0 and D=1.
- R3: Selector comparisons add the offsets to the base modulo 2^16. Neither fast path issues a table request.
- R4: Any other selector pair raises `tbl_req` with both selectors presented, and holds it until `tbl_ack`. If the walker reports a fault, the result is a general-protection fault (kind 1) whose error code is the walker's selector. Otherwise the returned descriptors are adopted.
- R5: On the table path, a CS or SS selector whose bits 15:2 are zero gives a general-protection fault with error 0 and no table request.
- R6: With CS.L=1, an instruction pointer whose bits 63:47 are not all equal to bit 47 gives a general-protection fault with error 0.
- R7: With CS.L=0, bits 63:32 of the instruction and stack pointers are cleared. A general-protection fault is raised if the low half of the instruction pointer exceeds the limit. The limit is the raw value when G=0, and the value shifted left by 12 with 0xFFF filled below when G=1.
- R8: With user shadow stacks enabled and CS.L=0, a user shadow-stack pointer with a nonzero upper half gives a general-protection fault.
- R9: With supervisor shadow stacks enabled, a current shadow-stack pointer that differs from the level-0 event value gives a control-protection fault (kind 2). General-protection checks take precedence.
- R10: On success the privilege output becomes 3 and the GS base and kernel GS base swap. With user shadow stacks enabled, the user pointer is loaded and `ssp_load` pulses.
- R11: On success, `nmi_unblock` pulses with the frame's NMI flag. `pend_db` pulses only when the pending flag is set and bit 8 (TF) of the new flags is 1.
- R12: A fault reports `fault_vld`=1 with `done` and changes no state output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin finalizing the presented frame (sampled when idle) |
| fr_rip | input | 64 | Frame instruction pointer |
| fr_cs_sel | input | 16 | Frame code selector |
| fr_ss_sel | input | 16 | Frame stack selector |
| fr_rflags | input | 64 | Frame flags image |
| fr_rsp | input | 64 | Frame stack pointer |
| fr_pend_db | input | 1 | Pending single-step flag from the frame |
| fr_nmi_unblk | input | 1 | NMI-unblock flag from the frame |
| sel_base | input | 16 | Selector base for fast-path decoding |
| ush_en | input | 1 | User shadow stacks enabled |
| ssh_en | input | 1 | Supervisor shadow stacks enabled |
| user_ssp | input | 64 | User shadow-stack pointer |
| cur_ssp | input | 64 | Current shadow-stack pointer |
| evt_ssp0 | input | 64 | Level-0 event shadow-stack pointer |
| gs_base_in | input | 64 | Current GS base |
| kgs_base_in | input | 64 | Current kernel GS base |
| tbl_req | output | 1 | Descriptor-table lookup request |
| tbl_cs_sel | output | 16 | CS selector for the lookup |
| tbl_ss_sel | output | 16 | SS selector for the lookup |
| tbl_ack | input | 1 | Lookup complete |
| tbl_fault | input | 1 | Lookup failed |
| tbl_fault_sel | input | 16 | Selector blamed by a failed lookup |
| tbl_cs_desc | input | 63 | Looked-up CS descriptor (R1 packing) |
| tbl_ss_desc | input | 63 | Looked-up SS descriptor (R1 packing) |
| done | output | 1 | One-cycle completion pulse |
| fault_vld | output | 1 | Last completion faulted |
| fault_kind | output | 2 | 0 none, 1 general protection, 2 control protection |
| fault_err | output | 16 | Fault error code |
| out_rip | output | 64 | Final instruction pointer |
| out_rsp | output | 64 | Final stack pointer |
| out_rflags | output | 64 | Final flags |
| out_cs_sel | output | 16 | Final CS selector |
| out_ss_sel | output | 16 | Final SS selector |
| out_cs_desc | output | 63 | Final CS descriptor |
| out_ss_desc | output | 63 | Final SS descriptor |
| out_cpl | output | 2 | Privilege level |
| out_gs_base | output | 64 | New GS base |
| out_kgs_base | output | 64 | New kernel GS base |
| out_ssp | output | 64 | Loaded shadow-stack pointer |
| ssp_load | output | 1 | Shadow-stack pointer loaded this completion |
| nmi_unblock | output | 1 | Request to unblock NMIs |
| pend_db | output | 1 | Request a pending single-step trap |

## Verification
The bench sets a selector base near 0xFFFF so that the fast-path sums wrap. A design that compares with widened arithmetic would then send a valid 64-bit return to the table walker. It checks the limit at exactly the last legal byte and one past it, with G both clear and set; an off-by-one or a missing 0xFFF fill would fault a legal return or accept an illegal one. A non-canonical pointer is driven with bit 47 alone set, which an implementation checking only bits 63:48 would miss. After each fault the bench confirms that no state output moved, and it drives the single-step flag with TF both clear and set, to expose a trap that ignores TF.

// File: rtl/ufin_pkg.sv
package ufin_pkg;

  localparam int unsigned XLEN = 64;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic [3:0]  typ;
    logic        s;
    logic [1:0]  dpl;
    logic        p;
    logic        l;
    logic        db;
    logic        g;
  } seg_desc_t;

  localparam int unsigned DESC_W = $bits(seg_desc_t);

  typedef enum logic [1:0] {
    PATH_FAST64 = 2'd0,
    PATH_COMPAT = 2'd1,
    PATH_TABLE  = 2'd2
  } ret_path_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_CP   = 2'd2
  } fault_e;

  // Flat user code segment; long_mode picks L=1/D=0 or L=0/D=1.
  function automatic seg_desc_t fixed_cs(input logic long_mode);
    seg_desc_t d;
    d.base  = '0;
    d.limit = 20'hFFFFF;
    d.typ   = 4'd11;
    d.s     = 1'b1;
    d.dpl   = 2'd3;
    d.p     = 1'b1;
    d.l     = long_mode;
    d.db    = ~long_mode;
    d.g     = 1'b1;
    return d;
  endfunction

  function automatic seg_desc_t fixed_ss();
    seg_desc_t d;
    d.base  = '0;
    d.limit = 20'hFFFFF;
    d.typ   = 4'd3;
    d.s     = 1'b1;
    d.dpl   = 2'd3;
    d.p     = 1'b1;
    d.l     = 1'b0;
    d.db    = 1'b1;
    d.g     = 1'b1;
    return d;
  endfunction

  // True when every bit from vbits-1 upward matches bit vbits-1.
  function automatic logic is_canonical(input logic [XLEN-1:0] a, input int unsigned vbits);
    logic [XLEN-1:0] hi;
    logic [XLEN-1:0] ones;
    hi   = a >> (vbits - 1);
    ones = {XLEN{1'b1}} >> (vbits - 1);
    return (hi == '0) || (hi == ones);
  endfunction

  function automatic logic [31:0] scaled_limit(input logic [19:0] lim, input logic gran);
    return gran ? {lim, 12'hFFF} : {12'h000, lim};
  endfunction

endpackage

// File: rtl/ufin_path_decode.sv
module ufin_path_decode
  import ufin_pkg::*;
#(
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned CS64_OFF = 16,
  parameter int unsigned SS_OFF   = 8
) (
  input  logic [SEL_W-1:0] cs_sel,
  input  logic [SEL_W-1:0] ss_sel,
  input  logic [SEL_W-1:0] base,
  output ret_path_e        path,
  output logic             null_fault
);
  logic [SEL_W-1:0] cs64_sel;
  logic [SEL_W-1:0] ss_fast_sel;
  logic             hit64;
  logic             hitc;

  assign cs64_sel    = base + SEL_W'(CS64_OFF);
  assign ss_fast_sel = base + SEL_W'(SS_OFF);
  assign hit64       = (cs_sel == cs64_sel) && (ss_sel == ss_fast_sel);
  assign hitc        = (cs_sel == base) && (ss_sel == ss_fast_sel);

  always_comb begin
    if (hit64)     path = PATH_FAST64;
    else if (hitc) path = PATH_COMPAT;
    else           path = PATH_TABLE;
  end

  assign null_fault = (path == PATH_TABLE) &&
                      ((cs_sel[SEL_W-1:2] == '0) || (ss_sel[SEL_W-1:2] == '0));
endmodule

// File: rtl/ufin_target_check.sv
module ufin_target_check
  import ufin_pkg::*;
#(
  parameter int unsigned VA_BITS = 48
) (
  input  logic            cs_long,
  input  logic            cs_gran,
  input  logic [19:0]     cs_limit,
  input  logic [XLEN-1:0] rip,
  input  logic [XLEN-1:0] rsp,
  input  logic            ush_en,
  input  logic            ssh_en,
  input  logic [31:0]     ussp_hi,
  input  logic [XLEN-1:0] cur_ssp,
  input  logic [XLEN-1:0] evt_ssp0,
  output logic [XLEN-1:0] fin_rip,
  output logic [XLEN-1:0] fin_rsp,
  output logic            canon_bad,
  output logic            limit_bad,
  output logic            ussp_bad,
  output logic            cp_bad,
  output fault_e          kind
);
  logic compat;

  assign compat    = ~cs_long;
  assign fin_rip   = compat ? {32'h0, rip[31:0]} : rip;
  assign fin_rsp   = compat ? {32'h0, rsp[31:0]} : rsp;
  assign canon_bad = cs_long && !is_canonical(rip, VA_BITS);
  assign limit_bad = compat && (rip[31:0] > scaled_limit(cs_limit, cs_gran));
  assign ussp_bad  = ush_en && compat && (ussp_hi != 32'h0);
  assign cp_bad    = ssh_en && (cur_ssp != evt_ssp0);

  always_comb begin
    if (canon_bad || limit_bad || ussp_bad) kind = FLT_GP;
    else if (cp_bad)                        kind = FLT_CP;
    else                                    kind = FLT_NONE;
  end
endmodule

// File: rtl/user_return_finalizer.sv
module user_return_finalizer
  import ufin_pkg::*;
#(
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned VA_BITS  = 48,
  parameter int unsigned CS64_OFF = 16,
  parameter int unsigned SS_OFF   = 8,
  parameter int unsigned TF_BIT   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [63:0]        fr_rip,
  input  logic [SEL_W-1:0]   fr_cs_sel,
  input  logic [SEL_W-1:0]   fr_ss_sel,
  input  logic [63:0]        fr_rflags,
  input  logic [63:0]        fr_rsp,
  input  logic               fr_pend_db,
  input  logic               fr_nmi_unblk,
  input  logic [SEL_W-1:0]   sel_base,
  input  logic               ush_en,
  input  logic               ssh_en,
  input  logic [63:0]        user_ssp,
  input  logic [63:0]        cur_ssp,
  input  logic [63:0]        evt_ssp0,
  input  logic [63:0]        gs_base_in,
  input  logic [63:0]        kgs_base_in,
  output logic               tbl_req,
  output logic [SEL_W-1:0]   tbl_cs_sel,
  output logic [SEL_W-1:0]   tbl_ss_sel,
  input  logic               tbl_ack,
  input  logic               tbl_fault,
  input  logic [SEL_W-1:0]   tbl_fault_sel,
  input  logic [62:0]        tbl_cs_desc,
  input  logic [62:0]        tbl_ss_desc,
  output logic               done,
  output logic               fault_vld,
  output logic [1:0]         fault_kind,
  output logic [SEL_W-1:0]   fault_err,
  output logic [63:0]        out_rip,
  output logic [63:0]        out_rsp,
  output logic [63:0]        out_rflags,
  output logic [SEL_W-1:0]   out_cs_sel,
  output logic [SEL_W-1:0]   out_ss_sel,
  output logic [62:0]        out_cs_desc,
  output logic [62:0]        out_ss_desc,
  output logic [1:0]         out_cpl,
  output logic [63:0]        out_gs_base,
  output logic [63:0]        out_kgs_base,
  output logic [63:0]        out_ssp,
  output logic               ssp_load,
  output logic               nmi_unblock,
  output logic               pend_db
);
  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_WAIT, S_FIN} st_e;

  st_e                st_q;
  logic [63:0]        rip_q, rsp_q, rflags_q;
  logic [SEL_W-1:0]   cs_q, ss_q;
  logic               pend_q, nmi_q;
  seg_desc_t          cs_d_q, ss_d_q;

  // Named internal events for the checker
  ret_path_e          path;
  logic               null_fault;
  logic [63:0]        fin_rip, fin_rsp;
  logic               canon_bad, limit_bad, ussp_bad, cp_bad;
  fault_e             chk_kind;
  logic               commit_ev;

  ufin_path_decode #(
    .SEL_W(SEL_W), .CS64_OFF(CS64_OFF), .SS_OFF(SS_OFF)
  ) u_dec (
    .cs_sel(cs_q), .ss_sel(ss_q), .base(sel_base),
    .path(path), .null_fault(null_fault)
  );

  ufin_target_check #(.VA_BITS(VA_BITS)) u_chk (
    .cs_long(cs_d_q.l), .cs_gran(cs_d_q.g), .cs_limit(cs_d_q.limit),
    .rip(rip_q), .rsp(rsp_q),
    .ush_en(ush_en), .ssh_en(ssh_en), .ussp_hi(user_ssp[63:32]),
    .cur_ssp(cur_ssp), .evt_ssp0(evt_ssp0),
    .fin_rip(fin_rip), .fin_rsp(fin_rsp),
    .canon_bad(canon_bad), .limit_bad(limit_bad),
    .ussp_bad(ussp_bad), .cp_bad(cp_bad), .kind(chk_kind)
  );

  assign tbl_req    = (st_q == S_WAIT);
  assign tbl_cs_sel = cs_q;
  assign tbl_ss_sel = ss_q;
  assign commit_ev  = (st_q == S_FIN) && (chk_kind == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      rip_q <= '0; rsp_q <= '0; rflags_q <= '0;
      cs_q <= '0; ss_q <= '0; pend_q <= 1'b0; nmi_q <= 1'b0;
      cs_d_q <= '0; ss_d_q <= '0;
      done <= 1'b0; fault_vld <= 1'b0; fault_kind <= FLT_NONE; fault_err <= '0;
      out_rip <= '0; out_rsp <= '0; out_rflags <= '0;
      out_cs_sel <= '0; out_ss_sel <= '0; out_cs_desc <= '0; out_ss_desc <= '0;
      out_cpl <= 2'd0; out_gs_base <= '0; out_kgs_base <= '0; out_ssp <= '0;
      ssp_load <= 1'b0; nmi_unblock <= 1'b0; pend_db <= 1'b0;
    end else begin
      done        <= 1'b0;
      ssp_load    <= 1'b0;
      nmi_unblock <= 1'b0;
      pend_db     <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          rip_q <= fr_rip; rsp_q <= fr_rsp; rflags_q <= fr_rflags;
          cs_q <= fr_cs_sel; ss_q <= fr_ss_sel;
          pend_q <= fr_pend_db; nmi_q <= fr_nmi_unblk;
          st_q <= S_DECODE;
        end
        S_DECODE: begin
          unique case (path)
            PATH_FAST64: begin
              cs_d_q <= fixed_cs(1'b1); ss_d_q <= fixed_ss(); st_q <= S_FIN;
            end
            PATH_COMPAT: begin
              cs_d_q <= fixed_cs(1'b0); ss_d_q <= fixed_ss(); st_q <= S_FIN;
            end
            default: begin
              if (null_fault) begin
                done <= 1'b1; fault_vld <= 1'b1;
                fault_kind <= FLT_GP; fault_err <= '0;
                st_q <= S_IDLE;
              end else begin
                st_q <= S_WAIT;
              end
            end
          endcase
        end
        S_WAIT: if (tbl_ack) begin
          if (tbl_fault) begin
            done <= 1'b1; fault_vld <= 1'b1;
            fault_kind <= FLT_GP; fault_err <= tbl_fault_sel;
            st_q <= S_IDLE;
          end else begin
            cs_d_q <= tbl_cs_desc; ss_d_q <= tbl_ss_desc;
            st_q <= S_FIN;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st_q <= S_IDLE;
          fault_kind <= chk_kind;
          fault_err  <= '0;
          if (chk_kind != FLT_NONE) begin
            fault_vld <= 1'b1;
          end else begin
            fault_vld    <= 1'b0;
            out_rip      <= fin_rip;
            out_rsp      <= fin_rsp;
            out_rflags   <= rflags_q;
            out_cs_sel   <= cs_q;
            out_ss_sel   <= ss_q;
            out_cs_desc  <= cs_d_q;
            out_ss_desc  <= ss_d_q;
            out_cpl      <= 2'd3;
            out_gs_base  <= kgs_base_in;
            out_kgs_base <= gs_base_in;
            if (ush_en) begin
              out_ssp  <= user_ssp;
              ssp_load <= 1'b1;
            end
            nmi_unblock <= nmi_q;
            pend_db     <= pend_q & rflags_q[TF_BIT];
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ufin_checker.sv
module ufin_checker #(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned VA_BITS = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               done,
  input logic               fault_vld,
  input logic [SEL_W-1:0]   sel_base,
  input logic [SEL_W-1:0]   out_cs_sel,
  input logic [SEL_W-1:0]   out_ss_sel,
  input logic               cs_l,
  input logic               cs_d,
  input logic [1:0]         cs_dpl,
  input logic [64-VA_BITS:0] rip_top,
  input logic [31:0]        rip_hi,
  input logic [31:0]        rsp_hi,
  input logic [1:0]         out_cpl,
  input logic               new_tf,
  input logic               pend_db,
  input logic               nmi_unblock,
  input logic               tbl_req,
  input logic               tbl_ack,
  input logic [SEL_W-1:0]   tbl_cs_sel,
  input logic [SEL_W-1:0]   tbl_ss_sel,
  input logic               commit_ev
);
  logic ok_done;
  assign ok_done = done && !fault_vld;

  // R1
  assert_fast64_desc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ok_done && out_cs_sel == SEL_W'(sel_base + SEL_W'(16)) && out_ss_sel == SEL_W'(sel_base + SEL_W'(8))
    |-> cs_l && !cs_d && cs_dpl == 2'd3);

  // R2
  assert_compat_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ok_done && out_cs_sel == sel_base && out_ss_sel == SEL_W'(sel_base + SEL_W'(8))
    |-> !cs_l && cs_d);

  // R4
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req && !tbl_ack |=> tbl_req);

  // R5
  assert_no_null_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> (tbl_cs_sel[SEL_W-1:2] != '0) && (tbl_ss_sel[SEL_W-1:2] != '0));

  // R6
  assert_canon_rip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_done && cs_l |-> (&rip_top) || (~|rip_top));

  // R7
  assert_compat_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ok_done && !cs_l |-> rip_hi == 32'h0 && rsp_hi == 32'h0);

  // R10
  assert_cpl3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> out_cpl == 2'd3 && done && !fault_vld);

  // R11
  assert_pend_tf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_db |-> ok_done && new_tf);

  assert_nmi_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_unblock |-> ok_done);

  // R12
  assert_fault_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_vld |-> $stable(out_cpl) && $stable(out_cs_sel) && $stable(rip_hi));
endmodule

bind user_return_finalizer ufin_checker #(.SEL_W(SEL_W), .VA_BITS(VA_BITS)) u_ufin_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fault_vld(fault_vld),
  .sel_base(sel_base), .out_cs_sel(out_cs_sel), .out_ss_sel(out_ss_sel),
  .cs_l(out_cs_desc[2]), .cs_d(out_cs_desc[1]), .cs_dpl(out_cs_desc[5:4]),
  .rip_top(out_rip[63:VA_BITS-1]), .rip_hi(out_rip[63:32]), .rsp_hi(out_rsp[63:32]),
  .out_cpl(out_cpl), .new_tf(out_rflags[8]), .pend_db(pend_db), .nmi_unblock(nmi_unblock),
  .tbl_req(tbl_req), .tbl_ack(tbl_ack), .tbl_cs_sel(tbl_cs_sel), .tbl_ss_sel(tbl_ss_sel),
  .commit_ev(commit_ev)
);

// File: tb/sim_user_return_finalizer.sv
module sim_user_return_finalizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0;
  logic [63:0] fr_rip = 0, fr_rflags = 64'h2, fr_rsp = 0;
  logic [15:0] fr_cs_sel = 0, fr_ss_sel = 0, sel_base = 16'h0010;
  logic fr_pend_db = 0, fr_nmi_unblk = 0, ush_en = 0, ssh_en = 0;
  logic [63:0] user_ssp = 0, cur_ssp = 0, evt_ssp0 = 0;
  logic [63:0] gs_base_in = 64'hAAAA_0000_1111_2222, kgs_base_in = 64'h5555_0000_3333_4444;
  logic tbl_req, tbl_ack = 0, tbl_fault = 0;
  logic [15:0] tbl_cs_sel, tbl_ss_sel, tbl_fault_sel = 0;
  logic [62:0] tbl_cs_desc = 0, tbl_ss_desc = 0;
  logic done, fault_vld, ssp_load, nmi_unblock, pend_db;
  logic [1:0] fault_kind, out_cpl;
  logic [15:0] fault_err, out_cs_sel, out_ss_sel;
  logic [63:0] out_rip, out_rsp, out_rflags, out_gs_base, out_kgs_base, out_ssp;
  logic [62:0] out_cs_desc, out_ss_desc;

  user_return_finalizer u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit saw_req, got_done, c_ssp_load, c_nmi, c_pend;
  logic [15:0] req_cs, req_ss;

  function automatic logic [62:0] mk_desc(input logic [19:0] lim, input logic [3:0] typ,
                                          input logic l, input logic db, input logic g);
    return {32'h0, lim, typ, 1'b1, 2'd3, 1'b1, l, db, g};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic run(input logic [15:0] cs, input logic [15:0] ss,
                     input logic [63:0] rip, input logic [63:0] rsp, input logic [63:0] fl,
                     input logic pend, input logic nmi);
    int ack_wait;
    saw_req = 0; got_done = 0; c_ssp_load = 0; c_nmi = 0; c_pend = 0; ack_wait = 0;
    @(negedge clk);
    fr_cs_sel = cs; fr_ss_sel = ss; fr_rip = rip; fr_rsp = rsp; fr_rflags = fl;
    fr_pend_db = pend; fr_nmi_unblk = nmi; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 40 && !got_done; i++) begin
      tbl_ack = 0;
      if (done) begin
        got_done = 1; c_ssp_load = ssp_load; c_nmi = nmi_unblock; c_pend = pend_db;
      end else if (tbl_req) begin
        if (!saw_req) begin req_cs = tbl_cs_sel; req_ss = tbl_ss_sel; end
        saw_req = 1;
        ack_wait++;
        if (ack_wait == 3) tbl_ack = 1;
      end
      if (!got_done) @(negedge clk);
    end
    tbl_ack = 0;
    chk(got_done, "done-watch", {63'h0, got_done}, 64'h1);
  endtask

  localparam logic [62:0] CS64 = {32'h0, 20'hFFFFF, 4'd11, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [62:0] CSC  = {32'h0, 20'hFFFFF, 4'd11, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [62:0] SSF  = {32'h0, 20'hFFFFF, 4'd3,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic t_reset();
    chk_eq("R10 reset cpl", out_cpl, 0);
    chk_eq("R4 reset req", tbl_req, 0);
    chk_eq("R12 reset done", done, 0);
  endtask

  task automatic t_fast64();
    sel_base = 16'h0010;
    run(16'h0020, 16'h0018, 64'hFFFF_8000_0000_1000, 64'h1234_0000_0000_8000, 64'h202, 0, 0);
    chk_eq("R1 no fault", fault_vld, 0);
    chk_eq("R1 cs desc", out_cs_desc, CS64);
    chk_eq("R1 ss desc", out_ss_desc, SSF);
    chk_eq("R1 rip kept", out_rip, 64'hFFFF_8000_0000_1000);
    chk_eq("R1 rsp kept", out_rsp, 64'h1234_0000_0000_8000);
    chk_eq("R3 no table req", saw_req, 0);
    chk_eq("R10 cpl", out_cpl, 3);
    chk_eq("R10 gs", out_gs_base, kgs_base_in);
    chk_eq("R10 kgs", out_kgs_base, gs_base_in);
    chk_eq("R10 no ssp load", c_ssp_load, 0);
  endtask

  task automatic t_compat();
    sel_base = 16'h0010;
    run(16'h0010, 16'h0018, 64'h1234_5678_0000_4000, 64'hFFFF_0000_0000_0100, 64'h2, 0, 0);
    chk_eq("R2 no fault", fault_vld, 0);
    chk_eq("R2 cs desc", out_cs_desc, CSC);
    chk_eq("R7 rip upper cleared", out_rip, 64'h4000);
    chk_eq("R7 rsp upper cleared", out_rsp, 64'h100);
  endtask

  task automatic t_wrap();
    sel_base = 16'hFFF0;
    run(16'h0000, 16'hFFF8, 64'h1000, 64'h10, 64'h2, 0, 0);
    chk_eq("R3 wrapped fast64", out_cs_desc, CS64);
    chk_eq("R3 wrap no req", saw_req, 0);
    chk_eq("R3 wrap sel", out_cs_sel, 16'h0000);
    sel_base = 16'h0010;
  endtask

  task automatic t_table();
    tbl_fault = 0;
    tbl_cs_desc = mk_desc(20'h00FFF, 4'd11, 1, 0, 0);
    tbl_ss_desc = mk_desc(20'h00FFF, 4'd3, 0, 1, 0);
    run(16'h0033, 16'h002B, 64'h7FFF_FFFF_F000, 64'h50, 64'h2, 0, 0);
    chk_eq("R4 req seen", saw_req, 1);
    chk_eq("R4 req cs sel", req_cs, 16'h0033);
    chk_eq("R4 req ss sel", req_ss, 16'h002B);
    chk_eq("R4 no fault", fault_vld, 0);
    chk_eq("R4 cs desc adopted", out_cs_desc, tbl_cs_desc);
    chk_eq("R4 ss desc adopted", out_ss_desc, tbl_ss_desc);
  endtask

  task automatic t_table_fault();
    logic [63:0] prev_rip;
    prev_rip = out_rip;
    tbl_fault = 1; tbl_fault_sel = 16'h0033;
    run(16'h0033, 16'h002B, 64'h2000, 64'h50, 64'h2, 0, 1);
    chk_eq("R4 fault vld", fault_vld, 1);
    chk_eq("R4 fault kind", fault_kind, 1);
    chk_eq("R4 fault err", fault_err, 16'h0033);
    chk_eq("R12 rip unchanged", out_rip, prev_rip);
    chk_eq("R12 no nmi on fault", c_nmi, 0);
    tbl_fault = 0;
  endtask

  task automatic t_null_sel();
    run(16'h0003, 16'h002B, 64'h2000, 64'h50, 64'h2, 0, 0);
    chk_eq("R5 fault", fault_vld, 1);
    chk_eq("R5 kind", fault_kind, 1);
    chk_eq("R5 err zero", fault_err, 0);
    chk_eq("R5 no req", saw_req, 0);
  endtask

  task automatic t_noncanon();
    logic [63:0] prev_rip;
    prev_rip = out_rip;
    run(16'h0020, 16'h0018, 64'h0000_8000_0000_0000, 64'h50, 64'h2, 0, 0);
    chk_eq("R6 gp", fault_kind, 1);
    chk_eq("R6 fault vld", fault_vld, 1);
    chk_eq("R12 rip kept", out_rip, prev_rip);
    run(16'h0020, 16'h0018, 64'hFFFF_8000_0000_0000, 64'h50, 64'h2, 0, 0);
    chk_eq("R6 canonical ok", fault_vld, 0);
  endtask

  task automatic t_limit();
    tbl_fault = 0;
    tbl_cs_desc = mk_desc(20'h00FFF, 4'd11, 0, 1, 0);
    tbl_ss_desc = mk_desc(20'h00FFF, 4'd3, 0, 1, 0);
    run(16'h0033, 16'h002B, 64'h0FFF, 64'h50, 64'h2, 0, 0);
    chk_eq("R7 at limit ok", fault_vld, 0);
    run(16'h0033, 16'h002B, 64'h1000, 64'h50, 64'h2, 0, 0);
    chk_eq("R7 past limit gp", fault_kind, 1);
    tbl_cs_desc = mk_desc(20'h00001, 4'd11, 0, 1, 1);
    run(16'h0033, 16'h002B, 64'hABCD_0000_0000_1FFF, 64'h50, 64'h2, 0, 0);
    chk_eq("R7 scaled ok", fault_vld, 0);
    chk_eq("R7 scaled rip", out_rip, 64'h1FFF);
    run(16'h0033, 16'h002B, 64'h2000, 64'h50, 64'h2, 0, 0);
    chk_eq("R7 scaled past gp", fault_kind, 1);
  endtask

  task automatic t_ussp();
    ush_en = 1; user_ssp = 64'h1_0000_0000;
    run(16'h0010, 16'h0018, 64'h100, 64'h50, 64'h2, 0, 0);
    chk_eq("R8 compat ussp gp", fault_kind, 1);
    run(16'h0020, 16'h0018, 64'h100, 64'h50, 64'h2, 0, 0);
    chk_eq("R8 64-bit ok", fault_vld, 0);
    chk_eq("R10 ssp loaded", out_ssp, 64'h1_0000_0000);
    chk_eq("R10 ssp pulse", c_ssp_load, 1);
    ush_en = 0; user_ssp = 0;
  endtask

  task automatic t_cp();
    ssh_en = 1; cur_ssp = 64'h40; evt_ssp0 = 64'h48;
    run(16'h0020, 16'h0018, 64'h100, 64'h50, 64'h2, 0, 0);
    chk_eq("R9 cp kind", fault_kind, 2);
    run(16'h0020, 16'h0018, 64'h0000_8000_0000_0000, 64'h50, 64'h2, 0, 0);
    chk_eq("R9 gp precedes cp", fault_kind, 1);
    evt_ssp0 = 64'h40;
    run(16'h0020, 16'h0018, 64'h100, 64'h50, 64'h2, 0, 0);
    chk_eq("R9 match ok", fault_vld, 0);
    ssh_en = 0;
  endtask

  task automatic t_events();
    run(16'h0020, 16'h0018, 64'h100, 64'h50, 64'h102, 1, 1);
    chk_eq("R11 pend with tf", c_pend, 1);
    chk_eq("R11 nmi", c_nmi, 1);
    chk_eq("R11 flags", out_rflags, 64'h102);
    run(16'h0020, 16'h0018, 64'h100, 64'h50, 64'h002, 1, 0);
    chk_eq("R11 no pend without tf", c_pend, 0);
    chk_eq("R11 no nmi", c_nmi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fast64();
    t_compat();
    t_wrap();
    t_table();
    t_table_fault();
    t_null_sel();
    t_noncanon();
    t_limit();
    t_ussp();
    t_cp();
    t_events();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule